// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front-End

This block is the clocked control and address front-end of a pipelined burst static RAM, with a small behavioural array behind it. On each rising clock edge it samples two active-low address strobes, three chip enables, a global write strobe, per-lane write enables, an address-advance request and the address bus. From these it decides whether to start a new access at the external address, to step a running burst, to stay idle or to enter the deselected (sleep) state.

The processor-side strobe always reads and outranks the controller-side strobe. The controller-side strobe can read or write. A burst walks the two lowest address bits in one of two orders, linear or interleaved, chosen by a static mode input. The registered access command drives a lane-split array. Read data returns one clock after the read command, together with an output-enable flag.

Top module: `burst_sram_frontend`

## Requirements
- R1: When `strobe_p_n` is low, `en_main_n` is low, `en_hi` is high and `en_low_n` is low, the next clock loads `addr_in` into `acc_addr` and issues a read (`acc_rd`=1, `acc_wr`=0, `acc_lanes`=0), whatever `wr_n`, `lane_wr_n` and `strobe_c_n` are.
- R2: While `en_main_n` is high, `strobe_p_n` has no effect: with `strobe_c_n` high and `adv` low the address is kept and no access is issued.
- R3: A low `strobe_p_n` with `en_main_n` low but with `en_hi` low or `en_low_n` high sets `asleep` and issues no access.
- R4: When `strobe_c_n` is low, `strobe_p_n` is not active and all three enables are on, the next clock loads `addr_in`. It issues a read if `wr_n` is high and a write if `wr_n` is low; `acc_rd` and `acc_wr` are never high together.
- R5: A low `strobe_c_n` while `en_main_n` is high (and no processor access) sets `asleep` and issues no access.
- R6: When both strobes are low with all enables on, the access is a read at the new address.
- R7: With both strobes high, `adv` high and the block awake, the burst steps once and repeats the access kind given by `wr_n`. The upper address bits are kept. After four beats the address returns to the start. While asleep, `adv` has no effect.
- R8: With `mode_ilv` low the two low address bits follow start+n modulo 4.
- R9: With `mode_ilv` high the two low address bits follow start XOR n (start 1 gives 1,0,3,2).
- R10: A write stores only the lanes whose `lane_wr_n` bit is low. Lane k occupies data bits [9k+8:9k], and `acc_lanes` bit k is high exactly for those lanes.
- R11: `rdata_oe` goes high, with `rdata` holding the addressed word, one clock after `acc_rd` is high. `rdata_oe` is low and `rdata` is zero in every other cycle.
- R12: After reset `asleep` is 1 and `acc_rd`, `acc_wr` and `rdata_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ilv | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| strobe_p_n | input | 1 | Processor-side address strobe, active low, read only |
| strobe_c_n | input | 1 | Controller-side address strobe, active low |
| en_main_n | input | 1 | Primary chip enable, active low |
| en_hi | input | 1 | Secondary chip enable, active high |
| en_low_n | input | 1 | Secondary chip enable, active low |
| wr_n | input | 1 | Global write strobe, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| adv | input | 1 | Burst advance request |
| addr_in | input | ADDR_W | External address |
| wdata | input | LANES*LANE_W | Write data, sampled with the command |
| acc_addr | output | ADDR_W | Internal memory address |
| acc_rd | output | 1 | Registered read command |
| acc_wr | output | 1 | Registered write command |
| acc_lanes | output | LANES | Registered lane write strobes |
| rdata | output | LANES*LANE_W | Pipelined read data, zero when not driven |
| rdata_oe | output | 1 | Read data valid / output drive enable |
| asleep | output | 1 | Deselected (power-down) state |

## Verification
Two strobe functions can fall in the same cycle. The processor-side read start and the controller-side write start are provoked together by driving both strobes low, with `wr_n` low and every lane enabled. The result is judged correct only if the next cycle shows a read at the new address with no lane strobes, and the following cycle returns the stored word, not the write data. The table also lines up an advance with a lane-masked write at the wrap point, so that the burst wrap and the partial write land in one beat.

// File: rtl/bsf_pkg.sv
package bsf_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_SLEEP = 2'd3
  } op_e;

  // Low two address bits for beat cnt of a burst that began at start.
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/bsf_decode.sv
module bsf_decode
  import bsf_pkg::*;
(
  input  logic strobe_p_n,
  input  logic strobe_c_n,
  input  logic en_main_n,
  input  logic en_hi,
  input  logic en_low_n,
  input  logic wr_n,
  input  logic adv,
  input  logic awake,
  output op_e  op,
  output logic load,
  output logic step
);

  logic sec_ok;
  assign sec_ok = en_hi & ~en_low_n;

  always_comb begin
    op   = OP_IDLE;
    load = 1'b0;
    step = 1'b0;
    if (!strobe_p_n && !en_main_n) begin
      // processor strobe: read only, outranks the controller strobe
      if (sec_ok) begin
        op   = OP_READ;
        load = 1'b1;
      end else begin
        op = OP_SLEEP;
      end
    end else if (!strobe_c_n) begin
      if (!en_main_n && sec_ok) begin
        op   = wr_n ? OP_READ : OP_WRITE;
        load = 1'b1;
      end else begin
        op = OP_SLEEP;
      end
    end else if (adv && awake) begin
      op   = wr_n ? OP_READ : OP_WRITE;
      step = 1'b1;
    end
  end

endmodule

// File: rtl/bsf_burst.sv
module bsf_burst
  import bsf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_ilv,
  input  logic              load,
  input  logic              step,
  input  logic              sleep_req,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              awake
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      start_q;
  logic [1:0]      cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      awake   <= 1'b0;
    end else if (load) begin
      hi_q    <= addr_in[ADDR_W-1:2];
      start_q <= addr_in[1:0];
      cnt_q   <= '0;
      awake   <= 1'b1;
    end else if (sleep_req) begin
      awake   <= 1'b0;
    end else if (step) begin
      cnt_q   <= cnt_q + 2'd1;
    end
  end

  assign addr_out = {hi_q, burst_low(start_q, cnt_q, mode_ilv)};

endmodule

// File: rtl/bsf_stage.sv
module bsf_stage
  import bsf_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              acc_rd,
  output logic              acc_wr,
  output logic [LANES-1:0]  acc_lanes,
  output logic [DATA_W-1:0] wdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rd    <= 1'b0;
      acc_wr    <= 1'b0;
      acc_lanes <= '0;
    end else begin
      acc_rd    <= (op == OP_READ);
      acc_wr    <= (op == OP_WRITE);
      acc_lanes <= (op == OP_WRITE) ? ~lane_wr_n : '0;
    end
  end

  always_ff @(posedge clk) begin
    wdata_q <= wdata;
  end

endmodule

// File: rtl/bsf_array.sv
module bsf_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    rd,
  input  logic                    wr,
  input  logic [LANES-1:0]        lanes,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    oe
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] q_all;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q_lane;

    always_ff @(posedge clk) begin
      if (wr && lanes[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      q_lane <= mem[addr];
    end

    assign q_all[g*LANE_W +: LANE_W] = q_lane;
  end

  always_ff @(posedge clk) begin
    if (rst) oe <= 1'b0;
    else     oe <= rd;
  end

  assign rdata = oe ? q_all : '0;

endmodule

// File: rtl/burst_sram_frontend.sv
module burst_sram_frontend
  import bsf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_ilv,
  input  logic                    strobe_p_n,
  input  logic                    strobe_c_n,
  input  logic                    en_main_n,
  input  logic                    en_hi,
  input  logic                    en_low_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    adv,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [ADDR_W-1:0]       acc_addr,
  output logic                    acc_rd,
  output logic                    acc_wr,
  output logic [LANES-1:0]        acc_lanes,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe,
  output logic                    asleep
);

  localparam int DATA_W = LANES * LANE_W;

  op_e               op;
  logic              load;
  logic              step;
  logic              awake;
  logic [DATA_W-1:0] wdata_q;

  bsf_decode u_dec (
    .strobe_p_n (strobe_p_n),
    .strobe_c_n (strobe_c_n),
    .en_main_n  (en_main_n),
    .en_hi      (en_hi),
    .en_low_n   (en_low_n),
    .wr_n       (wr_n),
    .adv        (adv),
    .awake      (awake),
    .op         (op),
    .load       (load),
    .step       (step)
  );

  bsf_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst       (rst),
    .mode_ilv  (mode_ilv),
    .load      (load),
    .step      (step),
    .sleep_req (op == OP_SLEEP),
    .addr_in   (addr_in),
    .addr_out  (acc_addr),
    .awake     (awake)
  );

  bsf_stage #(.LANES(LANES), .DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .lane_wr_n (lane_wr_n),
    .wdata     (wdata),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_lanes (acc_lanes),
    .wdata_q   (wdata_q)
  );

  bsf_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .rst   (rst),
    .addr  (acc_addr),
    .rd    (acc_rd),
    .wr    (acc_wr),
    .lanes (acc_lanes),
    .wdata (wdata_q),
    .rdata (rdata),
    .oe    (rdata_oe)
  );

  assign asleep = ~awake;

endmodule

// File: rtl/bsf_checker.sv
module bsf_checker #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_ilv,
  input logic              strobe_p_n,
  input logic              strobe_c_n,
  input logic              en_main_n,
  input logic              en_hi,
  input logic              en_low_n,
  input logic              adv,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [LANES-1:0]  acc_lanes,
  input logic              rdata_oe,
  input logic              asleep
);

  AST_PROC_READ: assert property (@(posedge clk) disable iff (rst)
    (!strobe_p_n && !en_main_n && en_hi && !en_low_n)
      |=> (acc_rd && !acc_wr && acc_lanes == '0 && acc_addr == $past(addr_in))); // R1

  AST_PROC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (en_main_n && strobe_c_n && !adv)
      |=> (!acc_rd && !acc_wr && $stable(acc_addr))); // R2

  AST_PROC_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (!strobe_p_n && !en_main_n && (!en_hi || en_low_n))
      |=> (asleep && !acc_rd && !acc_wr)); // R3

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(acc_rd && acc_wr)); // R4

  AST_CTRL_SLEEP: assert property (@(posedge clk) disable iff (rst)
    (!strobe_c_n && en_main_n)
      |=> (asleep && !acc_rd && !acc_wr)); // R5

  AST_ADV_LINEAR: assert property (@(posedge clk) disable iff (rst)
    (!mode_ilv && adv && strobe_p_n && strobe_c_n && !asleep)
      |=> (acc_addr[1:0] == $past(acc_addr[1:0]) + 2'd1)); // R8

  AST_ADV_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (adv && strobe_p_n && strobe_c_n)
      |=> $stable(acc_addr[ADDR_W-1:2])); // R7

  AST_LANES_ONLY_WR: assert property (@(posedge clk) disable iff (rst)
    (acc_lanes != '0) |-> acc_wr); // R10

  AST_OE_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    acc_rd |=> rdata_oe); // R11

  AST_OE_NEEDS_RD: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> !rdata_oe); // R11

endmodule

bind burst_sram_frontend bsf_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_ilv   (mode_ilv),
  .strobe_p_n (strobe_p_n),
  .strobe_c_n (strobe_c_n),
  .en_main_n  (en_main_n),
  .en_hi      (en_hi),
  .en_low_n   (en_low_n),
  .adv        (adv),
  .addr_in    (addr_in),
  .acc_addr   (acc_addr),
  .acc_rd     (acc_rd),
  .acc_wr     (acc_wr),
  .acc_lanes  (acc_lanes),
  .rdata_oe   (rdata_oe),
  .asleep     (asleep)
);

// File: tb/sim_burst_sram_frontend.sv
module sim_burst_sram_frontend;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_ilv = 1'b0;
  logic        strobe_p_n = 1'b1, strobe_c_n = 1'b1;
  logic        en_main_n = 1'b0, en_hi = 1'b1, en_low_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [3:0]  lane_wr_n = 4'hF;
  logic        adv = 1'b0;
  logic [7:0]  addr_in = '0;
  logic [35:0] wdata = '0;
  logic [7:0]  acc_addr;
  logic        acc_rd, acc_wr, rdata_oe, asleep;
  logic [3:0]  acc_lanes;
  logic [35:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_sram_frontend u0 (
    .clk(clk), .rst(rst), .mode_ilv(mode_ilv),
    .strobe_p_n(strobe_p_n), .strobe_c_n(strobe_c_n),
    .en_main_n(en_main_n), .en_hi(en_hi), .en_low_n(en_low_n),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .adv(adv),
    .addr_in(addr_in), .wdata(wdata),
    .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_lanes(acc_lanes), .rdata(rdata), .rdata_oe(rdata_oe),
    .asleep(asleep)
  );

  typedef struct packed {
    logic        ps_n, cs_n, ce_n, ce_hi, ce2_n, wn;
    logic [3:0]  ln_n;
    logic        av;
    logic [7:0]  a;
    logic [35:0] d;
    logic [7:0]  xa;
    logic        xrd, xwr;
    logic [3:0]  xln;
    logic        xslp, xoe;
    logic [35:0] xq;
  } vec_t;

  localparam logic [35:0] A0 = 36'h111111111;
  localparam logic [35:0] A1 = 36'h222222222;
  localparam logic [35:0] A2 = 36'h333333333;
  localparam logic [35:0] A3 = 36'h444444444;
  localparam logic [35:0] B0 = 36'h0000000AB;
  localparam logic [35:0] MX = 36'h1111110AB;
  localparam int NV = 18;

  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,8'h10,A0,  8'h10,1'b0,1'b1,4'hF,1'b0,1'b0,36'h0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,8'h00,A1,  8'h11,1'b0,1'b1,4'hF,1'b0,1'b0,36'h0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,8'h00,A2,  8'h12,1'b0,1'b1,4'hF,1'b0,1'b0,36'h0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'h0,1'b1,8'h00,A3,  8'h13,1'b0,1'b1,4'hF,1'b0,1'b0,36'h0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,4'hE,1'b1,8'h00,B0,  8'h10,1'b0,1'b1,4'h1,1'b0,1'b0,36'h0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,8'h12,36'hFFFFFFFFF, 8'h12,1'b1,1'b0,4'h0,1'b0,1'b0,36'h0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,8'h00,36'h0, 8'h13,1'b1,1'b0,4'h0,1'b0,1'b1,A2},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,8'h00,36'h0, 8'h10,1'b1,1'b0,4'h0,1'b0,1'b1,A3},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,8'h00,36'h0, 8'h11,1'b1,1'b0,4'h0,1'b0,1'b1,MX},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,8'h00,36'h0, 8'h11,1'b0,1'b0,4'h0,1'b0,1'b1,A1},
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,8'h55,36'h0, 8'h11,1'b0,1'b0,4'h0,1'b0,1'b0,36'h0},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,4'hF,1'b0,8'h66,36'h0, 8'h11,1'b0,1'b0,4'h0,1'b1,1'b0,36'h0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,8'h00,36'h0, 8'h11,1'b0,1'b0,4'h0,1'b1,1'b0,36'h0},
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,8'h13,36'h0, 8'h13,1'b1,1'b0,4'h0,1'b0,1'b0,36'h0},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b0,8'h77,36'h0, 8'h13,1'b0,1'b0,4'h0,1'b1,1'b1,A3},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,8'h00,36'h0, 8'h13,1'b0,1'b0,4'h0,1'b1,1'b0,36'h0},
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,4'h0,1'b0,8'h10,36'hFFFFFFFFF, 8'h10,1'b1,1'b0,4'h0,1'b0,1'b0,36'h0},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b0,8'h00,36'h0, 8'h10,1'b0,1'b0,4'h0,1'b0,1'b1,MX}
  };

  task automatic chk(input string tag, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    strobe_p_n = 1'b1; strobe_c_n = 1'b1;
    en_main_n = 1'b0; en_hi = 1'b1; en_low_n = 1'b0;
    wr_n = 1'b1; lane_wr_n = 4'hF; adv = 1'b0; addr_in = '0; wdata = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    do_reset();
    chk("R12", "asleep", {35'd0, asleep}, 36'd1);
    chk("R12", "acc_rd", {35'd0, acc_rd}, 36'd0);
    chk("R12", "acc_wr", {35'd0, acc_wr}, 36'd0);
    chk("R12", "rdata_oe", {35'd0, rdata_oe}, 36'd0);

    // Table: linear mode writes, wrap with lane mask (R10), reads (R1, R6),
    // ignored strobe (R2), sleeps (R3, R5), advance while asleep (R7)
    for (int i = 0; i < NV; i++) begin
      strobe_p_n = TBL[i].ps_n; strobe_c_n = TBL[i].cs_n;
      en_main_n = TBL[i].ce_n; en_hi = TBL[i].ce_hi; en_low_n = TBL[i].ce2_n;
      wr_n = TBL[i].wn; lane_wr_n = TBL[i].ln_n; adv = TBL[i].av;
      addr_in = TBL[i].a; wdata = TBL[i].d;
      @(negedge clk);
      chk("R7/R8", $sformatf("row%0d acc_addr", i), {28'd0, acc_addr}, {28'd0, TBL[i].xa});
      chk("R1/R4", $sformatf("row%0d acc_rd", i), {35'd0, acc_rd}, {35'd0, TBL[i].xrd});
      chk("R1/R4", $sformatf("row%0d acc_wr", i), {35'd0, acc_wr}, {35'd0, TBL[i].xwr});
      chk("R10", $sformatf("row%0d acc_lanes", i), {32'd0, acc_lanes}, {32'd0, TBL[i].xln});
      chk("R2/R3/R5", $sformatf("row%0d asleep", i), {35'd0, asleep}, {35'd0, TBL[i].xslp});
      chk("R11", $sformatf("row%0d rdata_oe", i), {35'd0, rdata_oe}, {35'd0, TBL[i].xoe});
      chk("R11", $sformatf("row%0d rdata", i), rdata, TBL[i].xq);
    end

    // R9: interleaved order from start 1 gives 1,0,3,2 then wraps (R7)
    mode_ilv = 1'b1;
    do_reset();
    strobe_p_n = 1'b0; addr_in = 8'h21;
    @(negedge clk);
    chk("R9", "ilv beat0", {28'd0, acc_addr}, 36'h21);
    idle_inputs(); adv = 1'b1;
    @(negedge clk);
    chk("R9", "ilv beat1", {28'd0, acc_addr}, 36'h20);
    @(negedge clk);
    chk("R9", "ilv beat2", {28'd0, acc_addr}, 36'h23);
    @(negedge clk);
    chk("R9", "ilv beat3", {28'd0, acc_addr}, 36'h22);
    @(negedge clk);
    chk("R7", "ilv wrap", {28'd0, acc_addr}, 36'h21);
    chk("R7", "ilv burst read", {35'd0, acc_rd}, 36'd1);
    idle_inputs();
    @(negedge clk);
    chk("R11", "oe after last read", {35'd0, rdata_oe}, 36'd1);
    @(negedge clk);
    chk("R11", "oe idle", {35'd0, rdata_oe}, 36'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule